// File: doc/BRIEF.md
# Three-Channel Interval Timer

This peripheral holds three free-running down-counters that share one tick input. Each counter counts ticks, and when it runs out it reloads its fixed start value. If that channel's interrupt enable is set, the reload also raises a sticky pending flag. A single interrupt line is the OR of the three pending flags.

Software reaches the block through eight byte-wide locations, using read and write strobes and a 3-bit offset. Two control registers share offset 0. A route bit, written through offset 1, picks which of them receives a write. One of these two control registers also holds the start command. Once the timers start, they run until reset. A host learns which channel fired by reading offset 1. It acknowledges a channel by reading that channel's low count byte.

Top module: `tri_interval_timer`

## Requirements
- R1: After reset all pending flags, interrupt enables, the route bit and the run state are 0, and irq is 0. The counters restart from their start values: 32 ticks for channel 1, 3200 for channel 2 and 801 for channel 3.
- R2: A write to offset 1 loads the route bit from data bit 0 and channel 2's interrupt enable from data bit 6.
- R3: A write to offset 0 with the route bit at 1 loads channel 1's enable from bit 6, and starts the timers if bit 0 is 0. With the route bit at 0, the write loads channel 3's enable from bit 6, and it never starts the timers.
- R4: No tick is counted before the start. After the start, every clock cycle with tick high moves each counter one step. Channel n reaches its end, and reloads, every 32, 3200 or 801 ticks.
- R5: A reload sets the channel's pending flag only when that channel's enable is 1. A set flag stays set until it is cleared.
- R6: A read of offset 1 returns the pending flags of channels 1, 2 and 3 in bits 0, 1 and 2, with bits 7..3 at 0. rdata is valid in the same cycle as rd_en.
- R7: A read of offset 3, 5 or 7 returns 0 and clears the pending flag of channel 1, 2 or 3 respectively, leaving the other flags unchanged.
- R8: irq is 1 exactly when at least one pending flag is set.
- R9: Reads of offsets 0, 2, 4 and 6 return 0 and change no state. Writes to offsets 2 to 7 change no state.
- R10: When a clearing read and a flag-setting reload of the same channel fall in the same cycle, the flag ends up set.
- R11: A write to offset 0 with the route bit at 1 and data bit 0 at 1 does not stop running timers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count enable shared by all channels |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational while rd_en is high |
| irq | output | 1 | Combined interrupt |

## Verification
A counter in the wrong state shows up as a pending flag that appears at offset 1 and on irq at the wrong tick. The bench samples the status at the tick before each expected reload and again at the reload itself, so an error of one tick is caught at the very next status read. If the route bit or an enable is wrong, a flag is missing or extra at the next reload of that channel, which can be as late as 3200 ticks later for channel 2. A clear that is lost or that hits the wrong channel shows at offset 1 on the read that follows.

// File: rtl/tit_pkg.sv
// Package for the three-channel interval timer.
// Holds the register offsets and the data bit positions that the control
// decode and the read path share. Assumes byte-wide registers and 3-bit offsets.
package tit_pkg;
    localparam int NUM_CH  = 3;
    localparam int ADDR_W  = 3;
    localparam int DATA_W  = 8;

    localparam logic [ADDR_W-1:0] OFS_CTRL   = 3'd0; // shared by both control regs
    localparam logic [ADDR_W-1:0] OFS_ROUTE  = 3'd1; // write: route reg, read: status

    localparam int BIT_ROUTE = 0;  // route bit in the offset 1 write
    localparam int BIT_HALT  = 0;  // start command is this bit written as 0
    localparam int BIT_IEN   = 6;  // interrupt enable bit in all control regs

    // Offset of the low count byte of channel ch (0-based): 3, 5, 7.
    function automatic logic [ADDR_W-1:0] low_byte_ofs(input int ch);
        return ADDR_W'(2 * ch + 3);
    endfunction
endpackage

// File: rtl/tit_ctrl.sv
// Control register decode for the three-channel interval timer.
// Holds the route bit, the three interrupt enables and the sticky run state.
// Assumes at most one of wr_en/rd_en matters for control (reads have no effect here).
module tit_ctrl
    import tit_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic                 run,
    output logic [NUM_CH-1:0]    ien
);
    logic route;

    // Decode offset 0 and offset 1 writes into route, enables and run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route <= 1'b0;
            ien   <= '0;
            run   <= 1'b0;
        end else if (wr_en) begin
            if (addr == OFS_ROUTE) begin
                route  <= wdata[BIT_ROUTE];
                ien[1] <= wdata[BIT_IEN];
            end else if (addr == OFS_CTRL) begin
                if (route) begin
                    ien[0] <= wdata[BIT_IEN];
                    if (!wdata[BIT_HALT])
                        run <= 1'b1;
                end else begin
                    ien[2] <= wdata[BIT_IEN];
                end
            end
        end
    end

    AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> run); // R11
    AST_START_NEEDS_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !(wr_en && addr == OFS_CTRL && route)) |=> !run); // R3
    AST_ROUTE_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == OFS_ROUTE) |=> $stable(route)); // R2
endmodule

// File: rtl/tit_channel.sv
// One down-counting channel of the interval timer.
// Counts ticks while run is high and reloads START_VAL when the count runs out.
// Raises a sticky pending flag on reload when enabled; the set wins over clr.
// Assumes START_VAL is non-zero.
module tit_channel #(
    parameter int          CNT_W     = 16,
    parameter logic [15:0] START_VAL = 16'd32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    input  logic ien,
    input  logic clr,
    output logic pend
);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(START_VAL);
    localparam logic [CNT_W-1:0] LAST   = CNT_W'(1);

    logic [CNT_W-1:0] count;
    logic             step;
    logic             wrap;

    assign step = run && tick;
    assign wrap = step && (count == LAST);

    // Count down one per tick, reloading instead of reaching zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= RELOAD;
        else if (wrap)
            count <= RELOAD;
        else if (step)
            count <= count - LAST;
    end

    // Pending flag: set on enabled reload, cleared by acknowledge read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= 1'b0;
        else if (wrap && ien)
            pend <= 1'b1;
        else if (clr)
            pend <= 1'b0;
    end

    AST_CNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        count != '0); // R4
    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(count)); // R4
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && ien) |=> pend); // R10
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !clr) |=> pend); // R5
    AST_FLAG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend && !(wrap && ien)) |=> !pend); // R5
endmodule

// File: rtl/tri_interval_timer.sv
// Top of the three-channel interval timer.
// Instantiates the control decode and three counting channels, builds the
// status read, the acknowledge-by-read clears and the combined interrupt.
// Assumes rd_en and wr_en are single-cycle strobes sampled on clk.
module tri_interval_timer
    import tit_pkg::*;
#(
    parameter int          CNT_W  = 16,
    parameter logic [15:0] START1 = 16'd32,
    parameter logic [15:0] START2 = 16'd3200,
    parameter logic [15:0] START3 = 16'd801
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    localparam logic [15:0] STARTS [NUM_CH] = '{START1, START2, START3};

    logic              run;
    logic [NUM_CH-1:0] ien;
    logic [NUM_CH-1:0] clr;
    logic [NUM_CH-1:0] pend;

    tit_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .run   (run),
        .ien   (ien)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        // Acknowledge: a read of this channel's low count byte.
        assign clr[g] = rd_en && (addr == low_byte_ofs(g));

        tit_channel #(
            .CNT_W     (CNT_W),
            .START_VAL (STARTS[g])
        ) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (run),
            .tick  (tick),
            .ien   (ien[g]),
            .clr   (clr[g]),
            .pend  (pend[g])
        );
    end

    // Read path: only the status offset returns non-zero data.
    always_comb begin
        rdata = '0;
        if (rd_en && addr == OFS_ROUTE)
            rdata[NUM_CH-1:0] = pend;
    end

    assign irq = |pend;

    AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr != OFS_ROUTE) |-> rdata == '0); // R9
    AST_STATUS_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[DATA_W-1:NUM_CH] == '0); // R6
    AST_IRQ_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == OFS_ROUTE) |-> (irq == (rdata != '0))); // R8
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 3'd3 && !(run && tick)) |=> !irq || (rdata == '0)); // R7
endmodule

// File: tb/tri_interval_timer_bench.sv
// Self-checking bench: a vector table walked by one loop, then directed cases.
module tri_interval_timer_bench;
    localparam int CLK_PERIOD = 10;

    localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_TK = 2'd2;

    typedef struct packed {
        logic [1:0]  kind;
        logic [2:0]  addr;
        logic [7:0]  data;
        logic [11:0] n;
        logic [7:0]  exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 56;
    localparam vec_t VEC [NV] = '{
        '{K_RD, 3'd1, 8'h00, 12'd0,    8'h00, 4'd1},  // R1 reset status
        '{K_WR, 3'd0, 8'h00, 12'd0,    8'h00, 4'd3},  // R3 route 0: no start
        '{K_TK, 3'd0, 8'h00, 12'd40,   8'h00, 4'd4},
        '{K_RD, 3'd1, 8'h00, 12'd0,    8'h00, 4'd4},  // R4
        '{K_WR, 3'd1, 8'h41, 12'd0,    8'h00, 4'd2},  // R2 route 1, ch2 en
        '{K_WR, 3'd0, 8'h40, 12'd0,    8'h00, 4'd3},  // R3 ch1 en + start
        '{K_TK, 3'd0, 8'h00, 12'd31,   8'h00, 4'd4},
        '{K_RD, 3'd1, 8'h00, 12'd0,    8'h00, 4'd4},  // R4 S=31
        '{K_TK, 3'd0, 8'h00, 12'd1,    8'h00, 4'd4},
        '{K_RD, 3'd1, 8'h00, 12'd0,    8'h01, 4'd5},  // R5 S=32
        '{K_RD, 3'd3, 8'h00, 12'd0,    8'h00, 4'd7},  // R7 ack ch1
        '{K_RD, 3'd1, 8'h00, 12'd0,    8'h00, 4'd7},
        '{K_WR, 3'd1, 8'h00, 12'd0,    8'h00, 4'd2},  // R2 route 0, ch2 off
        '{K_WR, 3'd0, 8'h41, 12'd0,    8'h00, 4'd3},  // R3 ch3 en
        '{K_TK, 3'd0, 8'h00, 12'd32,   8'h00, 4'd4},
        '{K_RD, 3'd1, 8'h00, 12'd0,    8'h01, 4'd3},  // R3 ch1 en kept, S=64
        '{K_RD, 3'd5, 8'h00, 12'd0,    8'h00, 4'd7},
        '{K_RD, 3'd1, 8'h00, 12'd0,    8'h01, 4'd7},  // R7 other flag kept
        '{K_RD, 3'd3, 8'h00, 12'd0,    8'h00, 4'd7},
        '{K_TK, 3'd0, 8'h00, 12'd736,  8'h00, 4'd4},
        '{K_RD, 3'd1, 8'h00, 12'd0,    8'h01, 4'd4},  // R4 S=800
        '{K_RD, 3'd3, 8'h00, 12'd0,    8'h00, 4'd7},
        '{K_TK, 3'd0, 8'h00, 12'd1,    8'h00, 4'd4},
        '{K_RD, 3'd1, 8'h00, 12'd0,    8'h04, 4'd5},  // R5 ch3 at S=801
        '{K_RD, 3'd7, 8'h00, 12'd0,    8'h00, 4'd7},
        '{K_RD, 3'd1, 8'h00, 12'd0,    8'h00, 4'd7},
        '{K_WR, 3'd2, 8'hFF, 12'd0,    8'h00, 4'd9},  // R9 ignored writes
        '{K_WR, 3'd3, 8'h01, 12'd0,    8'h00, 4'd9},
        '{K_WR, 3'd7, 8'h00, 12'd0,    8'h00, 4'd9},
        '{K_TK, 3'd0, 8'h00, 12'd30,   8'h00, 4'd9},
        '{K_RD, 3'd1, 8'h00, 12'd0,    8'h00, 4'd9},  // R9 S=831
        '{K_TK, 3'd0, 8'h00, 12'd1,    8'h00, 4'd9},
        '{K_RD, 3'd1, 8'h00, 12'd0,    8'h01, 4'd9},  // R9 S=832
        '{K_WR, 3'd1, 8'h01, 12'd0,    8'h00, 4'd2},  // route 1, ch2 off
        '{K_WR, 3'd0, 8'h41, 12'd0,    8'h00, 4'd11}, // R11 bit0=1
        '{K_RD, 3'd3, 8'h00, 12'd0,    8'h00, 4'd7},
        '{K_TK, 3'd0, 8'h00, 12'd32,   8'h00, 4'd11},
        '{K_RD, 3'd1, 8'h00, 12'd0,    8'h01, 4'd11}, // R11 still running, S=864
        '{K_WR, 3'd0, 8'h00, 12'd0,    8'h00, 4'd5},  // ch1 en off
        '{K_RD, 3'd3, 8'h00, 12'd0,    8'h00, 4'd7},
        '{K_TK, 3'd0, 8'h00, 12'd32,   8'h00, 4'd5},
        '{K_RD, 3'd1, 8'h00, 12'd0,    8'h00, 4'd5},  // R5 gated, S=896
        '{K_WR, 3'd1, 8'h41, 12'd0,    8'h00, 4'd2},  // R2 ch2 en
        '{K_TK, 3'd0, 8'h00, 12'd2303, 8'h00, 4'd4},
        '{K_RD, 3'd1, 8'h00, 12'd0,    8'h04, 4'd4},  // R4 S=3199
        '{K_TK, 3'd0, 8'h00, 12'd1,    8'h00, 4'd4},
        '{K_RD, 3'd1, 8'h00, 12'd0,    8'h06, 4'd2},  // R2 ch2 at S=3200
        '{K_RD, 3'd0, 8'h00, 12'd0,    8'h00, 4'd9},
        '{K_RD, 3'd2, 8'h00, 12'd0,    8'h00, 4'd9},
        '{K_RD, 3'd4, 8'h00, 12'd0,    8'h00, 4'd9},
        '{K_RD, 3'd6, 8'h00, 12'd0,    8'h00, 4'd9},
        '{K_RD, 3'd1, 8'h00, 12'd0,    8'h06, 4'd9},  // R9 no side effect
        '{K_RD, 3'd5, 8'h00, 12'd0,    8'h00, 4'd7},
        '{K_RD, 3'd1, 8'h00, 12'd0,    8'h04, 4'd7},
        '{K_RD, 3'd7, 8'h00, 12'd0,    8'h00, 4'd7},
        '{K_RD, 3'd1, 8'h00, 12'd0,    8'h00, 4'd6}   // R6
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tri_interval_timer u_tri_interval_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .irq   (irq)
    );

    task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Read, compare rdata; status reads also compare irq against the flags.
    task automatic do_read(input logic [2:0] a, input logic [7:0] exp, input int req);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1;
        check(req, rdata, exp);
        if (a == 3'd1) check(8, {7'b0, irq}, {7'b0, exp != 8'h00}); // R8
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic do_ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog: an overlong run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected<=100000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(1, {7'b0, irq}, 8'h00); // R1 irq low after reset

        for (int i = 0; i < NV; i++) begin
            case (VEC[i].kind)
                K_WR:    do_write(VEC[i].addr, VEC[i].data);
                K_RD:    do_read(VEC[i].addr, VEC[i].exp, int'(VEC[i].req));
                default: do_ticks(int'(VEC[i].n));
            endcase
        end

        // R10: ch3 reloads at S=4005; ack read lands on that same tick.
        do_ticks(804);
        @(negedge clk);
        tick = 1'b1; rd_en = 1'b1; addr = 3'd7;
        @(negedge clk);
        tick = 1'b0; rd_en = 1'b0;
        do_read(3'd1, 8'h04, 10); // R10 set wins

        // R1: reset in mid-run clears flags and restarts the counters.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(1, {7'b0, irq}, 8'h00); // R1
        do_read(3'd1, 8'h00, 1);
        do_write(3'd1, 8'h01);
        do_write(3'd0, 8'h40);
        do_ticks(31);
        do_read(3'd1, 8'h00, 1); // R1 counter back at start value
        do_ticks(1);
        do_read(3'd1, 8'h01, 1);

        finish_run();
    end
endmodule